// File: doc/BRIEF.md
# DDR2 Write Burst Capture Model

This block models the receiving side of a DDR2 device for write traffic. It watches the command pins on each rising clock edge and recognises a write. It then waits the configured write latency and checks that the data strobe shows its low preamble. After that it stores the burst's data beats into a small column-addressed array. Each clock carries two data and strobe samples: one for the first half of the clock, when the strobe rises, and one for the second half, when the strobe falls.

The block also guards the write recovery window. A precharge that arrives while a write is still pending, or too soon after the last data clock, raises a sticky violation flag. A write whose preamble is missing raises its own sticky flag, and that burst is dropped. While a write is pending, any further write command is ignored. The array has a combinational read port so that a bench or a neighbouring model can inspect what was stored.

Top module: `ddr2_wr_capture`

## Requirements
- R1: A write is accepted only when, at a rising clock edge, `cs_n`, `cas_n` and `we_n` are low and `ras_n` is high. Any other pin combination stores nothing.
- R2: With the write command in clock 0, the first data clock is clock WL = `cfg_add_lat` + `cfg_cas_lat` - 1. In each data clock, the beat on `dq_rise` is stored before the beat on `dq_fall`.
- R3: The preamble is satisfied when `dqs_fall` is 0 in clock WL-1. When WL is 1, that clock is the command clock itself.
- R4: `cfg_bl8`=0 stores 4 beats over 2 clocks. `cfg_bl8`=1 stores 8 beats over 4 clocks.
- R5: Beat i goes to column address (col with its low log2(BL) bits cleared) OR ((col + i) mod BL). The beats therefore wrap inside the burst-aligned block.
- R6: Values on `dq_rise` and `dq_fall` outside the data clocks of an accepted burst leave storage unchanged.
- R7: A precharge is `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0. If the last data clock is L, a precharge in clock L+k sets `err_wr_recovery` when k <= `cfg_twr`, or when a write is still pending. A precharge with k = `cfg_twr`+1 leaves the flag clear.
- R8: A write whose preamble check fails sets `err_preamble` and stores none of its beats.
- R9: Both error flags stay set until `err_clr` is high at a clock edge. That edge clears them.
- R10: After reset, both flags are 0 and every array word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| col_addr | input | COL_W | Starting column of a write |
| dq_rise | input | DQ_W | Data sample, first half of the clock |
| dq_fall | input | DQ_W | Data sample, second half of the clock |
| dqs_rise | input | 1 | Strobe sample, first half of the clock |
| dqs_fall | input | 1 | Strobe sample, second half of the clock |
| cfg_cas_lat | input | LAT_W | CAS latency in clocks (at least 2) |
| cfg_add_lat | input | LAT_W | Additive latency in clocks |
| cfg_bl8 | input | 1 | 1 selects 8-beat bursts, 0 selects 4-beat bursts |
| cfg_twr | input | TWR_W | Write recovery time in clocks |
| err_clr | input | 1 | Clears both error flags |
| rd_addr | input | COL_W | Array read address |
| rd_data | output | DQ_W | Array word at `rd_addr` |
| err_preamble | output | 1 | Sticky flag: a preamble was missing |
| err_wr_recovery | output | 1 | Sticky flag: a precharge came too early |

## Verification
The bench starts bursts in the middle of their aligned block, so a design that counts past the block edge instead of wrapping puts beats into the neighbouring block. It uses a latency of one, where the preamble falls in the command clock, and an additive latency that moves the data window. A counter that is off by one there would store garbage beats or flag a good preamble. It places precharges exactly at the last illegal clock and at the first legal clock of the recovery window, and it drives data around every burst. A design that is off by one at either end, or that keeps writing after the burst, would corrupt the array or misreport the flag.

// File: rtl/ddr2_wcap_pkg.sv
package ddr2_wcap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_BURST = 2'd2
    } wst_e;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_PRE   = 2'd2
    } cmd_e;
endpackage

// File: rtl/ddr2_cmd_decode.sv
module ddr2_cmd_decode
    import ddr2_wcap_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd_o
);
    always_comb begin
        cmd_o = CMD_NONE;
        if (!cs_n) begin
            if (ras_n && !cas_n && !we_n)      cmd_o = CMD_WRITE;
            else if (!ras_n && cas_n && !we_n) cmd_o = CMD_PRE;
        end
    end

    // R1: the two decoded commands never overlap
    always_comb begin
        assert_cmd_exclusive_R1: assert (!(cmd_o == CMD_WRITE && (!ras_n || cas_n)));
    end
endmodule

// File: rtl/ddr2_wr_sequencer.sv
module ddr2_wr_sequencer
    import ddr2_wcap_pkg::*;
#(
    parameter int COL_W = 6,
    parameter int LAT_W = 3,
    parameter int TWR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [LAT_W-1:0] cfg_cl_i,
    input  logic [LAT_W-1:0] cfg_al_i,
    input  logic             cfg_bl8_i,
    input  logic [TWR_W-1:0] cfg_twr_i,
    input  logic             dqs_f_i,
    input  logic             err_clr_i,
    output logic             we_o,
    output logic [COL_W-1:0] wa0_o,
    output logic [COL_W-1:0] wa1_o,
    output logic             err_pre_o,
    output logic             err_twr_o
);
    localparam int CNT_W = LAT_W + 1;

    typedef struct packed {
        wst_e             state;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       pair;
        logic [COL_W-1:0] col;
        logic             bl8;
        logic [TWR_W-1:0] twr_lat;
        logic [TWR_W-1:0] twr;
        logic             e_pre;
        logic             e_twr;
    } seq_t;

    seq_t q, d;

    logic [CNT_W-1:0] wl;
    logic [COL_W-1:0] mask, off0, off1, blk;
    logic [1:0]       pair_last;

    always_comb begin
        wl = {1'b0, cfg_al_i} + {1'b0, cfg_cl_i} - CNT_W'(1);

        mask      = q.bl8 ? COL_W'(7) : COL_W'(3);
        blk       = q.col & ~mask;
        off0      = COL_W'({q.pair, 1'b0});
        off1      = off0 + COL_W'(1);
        wa0_o     = blk | ((q.col + off0) & mask);
        wa1_o     = blk | ((q.col + off1) & mask);
        pair_last = q.bl8 ? 2'd3 : 2'd1;

        d    = q;
        we_o = 1'b0;

        if (err_clr_i) begin
            d.e_pre = 1'b0;
            d.e_twr = 1'b0;
        end
        if (q.twr != '0) d.twr = q.twr - TWR_W'(1);
        if (cmd_i == CMD_PRE && (q.state != ST_IDLE || q.twr != '0))
            d.e_twr = 1'b1;

        unique case (q.state)
            ST_IDLE: begin
                if (cmd_i == CMD_WRITE) begin
                    d.col     = col_i;
                    d.bl8     = cfg_bl8_i;
                    d.twr_lat = cfg_twr_i;
                    d.pair    = 2'd0;
                    if (wl <= CNT_W'(1)) begin
                        if (dqs_f_i) d.e_pre = 1'b1;
                        else         d.state = ST_BURST;
                    end else begin
                        d.cnt   = wl - CNT_W'(2);
                        d.state = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (q.cnt == '0) begin
                    if (dqs_f_i) begin
                        d.e_pre = 1'b1;
                        d.state = ST_IDLE;
                    end else begin
                        d.state = ST_BURST;
                    end
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            ST_BURST: begin
                we_o = 1'b1;
                if (q.pair == pair_last) begin
                    d.state = ST_IDLE;
                    d.twr   = q.twr_lat;
                end else begin
                    d.pair = q.pair + 2'd1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign err_pre_o = q.e_pre;
    assign err_twr_o = q.e_twr;

    assert_bad_preamble_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WAIT && q.cnt == '0 && dqs_f_i) |=> err_pre_o);
    assert_bad_preamble_no_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WAIT && q.cnt == '0 && dqs_f_i) |=> !we_o);
    assert_early_precharge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_PRE && (q.twr != '0 || q.state != ST_IDLE)) |=> err_twr_o);
    assert_pre_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pre_o && !err_clr_i) |=> err_pre_o);
    assert_twr_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_twr_o && !err_clr_i) |=> err_twr_o);
    assert_burst_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o && q.pair == pair_last) |=> !we_o);
endmodule

// File: rtl/ddr2_burst_store.sv
module ddr2_burst_store #(
    parameter int COL_W = 6,
    parameter int DQ_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [COL_W-1:0] wa0_i,
    input  logic [DQ_W-1:0]  wd0_i,
    input  logic [COL_W-1:0] wa1_i,
    input  logic [DQ_W-1:0]  wd1_i,
    input  logic [COL_W-1:0] ra_i,
    output logic [DQ_W-1:0]  rd_o
);
    localparam int DEPTH = 1 << COL_W;

    logic [DQ_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[wa0_i] <= wd0_i;
            mem_q[wa1_i] <= wd1_i;
        end
    end

    assign rd_o = mem_q[ra_i];

    assert_beat_pair_distinct_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (wa0_i != wa1_i));
endmodule

// File: rtl/ddr2_wr_capture.sv
module ddr2_wr_capture
    import ddr2_wcap_pkg::*;
#(
    parameter int COL_W = 6,
    parameter int DQ_W  = 8,
    parameter int LAT_W = 3,
    parameter int TWR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [COL_W-1:0] col_addr,
    input  logic [DQ_W-1:0]  dq_rise,
    input  logic [DQ_W-1:0]  dq_fall,
    input  logic             dqs_rise,
    input  logic             dqs_fall,
    input  logic [LAT_W-1:0] cfg_cas_lat,
    input  logic [LAT_W-1:0] cfg_add_lat,
    input  logic             cfg_bl8,
    input  logic [TWR_W-1:0] cfg_twr,
    input  logic             err_clr,
    input  logic [COL_W-1:0] rd_addr,
    output logic [DQ_W-1:0]  rd_data,
    output logic             err_preamble,
    output logic             err_wr_recovery
);
    cmd_e             cmd;
    logic             we;
    logic [COL_W-1:0] wa0, wa1;
    logic             dqs_rise_unused;

    assign dqs_rise_unused = dqs_rise;

    ddr2_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd_o (cmd)
    );

    ddr2_wr_sequencer #(.COL_W(COL_W), .LAT_W(LAT_W), .TWR_W(TWR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd),
        .col_i     (col_addr),
        .cfg_cl_i  (cfg_cas_lat),
        .cfg_al_i  (cfg_add_lat),
        .cfg_bl8_i (cfg_bl8),
        .cfg_twr_i (cfg_twr),
        .dqs_f_i   (dqs_fall),
        .err_clr_i (err_clr),
        .we_o      (we),
        .wa0_o     (wa0),
        .wa1_o     (wa1),
        .err_pre_o (err_preamble),
        .err_twr_o (err_wr_recovery)
    );

    ddr2_burst_store #(.COL_W(COL_W), .DQ_W(DQ_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (we),
        .wa0_i (wa0),
        .wd0_i (dq_rise),
        .wa1_i (wa1),
        .wd1_i (dq_fall),
        .ra_i  (rd_addr),
        .rd_o  (rd_data)
    );
endmodule

// File: tb/ddr2_wr_capture_tb.sv
module ddr2_wr_capture_tb_top;
    localparam int COL_W = 6;
    localparam int DQ_W  = 8;
    localparam int DEPTH = 1 << COL_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n, ras_n, cas_n, we_n;
    logic [COL_W-1:0] col_addr, rd_addr;
    logic [DQ_W-1:0]  dq_rise, dq_fall, rd_data;
    logic dqs_rise, dqs_fall, cfg_bl8, err_clr;
    logic [2:0] cfg_cas_lat, cfg_add_lat, cfg_twr;
    logic err_preamble, err_wr_recovery;

    int checks = 0;
    int errors = 0;
    int cyc_n  = 0;
    logic [DQ_W-1:0] exp_mem [DEPTH];

    always #5 clk = ~clk;
    always @(posedge clk) cyc_n <= cyc_n + 1;

    ddr2_wr_capture dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .col_addr(col_addr), .dq_rise(dq_rise), .dq_fall(dq_fall),
        .dqs_rise(dqs_rise), .dqs_fall(dqs_fall), .cfg_cas_lat(cfg_cas_lat),
        .cfg_add_lat(cfg_add_lat), .cfg_bl8(cfg_bl8), .cfg_twr(cfg_twr),
        .err_clr(err_clr), .rd_addr(rd_addr), .rd_data(rd_data),
        .err_preamble(err_preamble), .err_wr_recovery(err_wr_recovery)
    );

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        dqs_rise = 1'b1; dqs_fall = 1'b1;
        dq_rise = 8'hA5 ^ 8'(cyc_n);
        dq_fall = 8'h5A ^ 8'(cyc_n * 3);
    endtask

    task automatic check_mem(input string req);
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = COL_W'(a);
            #1;
            chk(int'(rd_data), int'(exp_mem[a]), req);
        end
    endtask

    // One write burst; pre_k > 0 puts a precharge in clock last+pre_k.
    task automatic run_write(input int col, input int cl, input int al, input bit bl8,
                             input bit good_pre, input bit real_cmd, input int twr,
                             input int pre_k, input int base);
        int wl, nb, last, span;
        wl   = al + cl - 1;
        nb   = bl8 ? 8 : 4;
        last = wl + nb / 2 - 1;
        span = last + ((pre_k + 1 > 3) ? pre_k + 1 : 3);
        cfg_cas_lat = 3'(cl); cfg_add_lat = 3'(al); cfg_bl8 = bl8; cfg_twr = 3'(twr);
        for (int c = 0; c <= span; c++) begin
            @(negedge clk);
            idle_bus();
            if (c == 0) begin
                cs_n = real_cmd ? 1'b0 : 1'b1;
                ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b0;
                col_addr = COL_W'(col);
            end
            if (c == wl - 1) dqs_fall = good_pre ? 1'b0 : 1'b1;
            if (c >= wl && c <= last) begin
                dqs_rise = 1'b1; dqs_fall = 1'b0;
                dq_rise = 8'(base + 2 * (c - wl));
                dq_fall = 8'(base + 2 * (c - wl) + 1);
            end
            if (pre_k > 0 && c == last + pre_k) begin
                cs_n = 1'b0; ras_n = 1'b0; cas_n = 1'b1; we_n = 1'b0;
            end
        end
        if (good_pre && real_cmd) begin
            for (int i = 0; i < nb; i++) begin
                int adr;
                adr = (col & ~(nb - 1)) | ((col + i) & (nb - 1));
                exp_mem[adr] = 8'(base + i);
            end
        end
    endtask

    task automatic pulse_clear();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk(int'(err_preamble), 0, "R10 preamble flag");
        chk(int'(err_wr_recovery), 0, "R10 recovery flag");
        check_mem("R10 array cleared");
    endtask

    task automatic t_bl4_wrap();
        run_write(6, 3, 0, 1'b0, 1'b1, 1'b1, 2, 0, 8'h10);
        check_mem("R2 R4 R5 bl4 wrap");
        chk(int'(err_preamble), 0, "R3 good preamble");
    endtask

    task automatic t_bl8_al();
        run_write(6'h2B, 4, 2, 1'b1, 1'b1, 1'b1, 2, 0, 8'h40);
        check_mem("R2 R4 R5 R6 bl8 additive latency");
    endtask

    task automatic t_wl_one();
        run_write(6'h11, 2, 0, 1'b0, 1'b1, 1'b1, 2, 0, 8'h70);
        check_mem("R2 R3 latency one");
        chk(int'(err_preamble), 0, "R3 preamble in command clock");
    endtask

    task automatic t_not_write();
        run_write(6'h20, 3, 0, 1'b0, 1'b1, 1'b0, 2, 0, 8'h90);
        check_mem("R1 R6 deselected command");
    endtask

    task automatic t_bad_pre();
        run_write(6'h30, 3, 1, 1'b0, 1'b0, 1'b1, 2, 0, 8'hC0);
        check_mem("R8 dropped burst");
        chk(int'(err_preamble), 1, "R8 preamble flag");
        chk(int'(err_wr_recovery), 0, "R8 other flag quiet");
        repeat (4) @(negedge clk);
        chk(int'(err_preamble), 1, "R9 flag sticky");
        pulse_clear();
        chk(int'(err_preamble), 0, "R9 flag cleared");
    endtask

    task automatic t_twr();
        run_write(6'h08, 3, 0, 1'b0, 1'b1, 1'b1, 3, 3, 8'hD0);
        @(negedge clk);
        chk(int'(err_wr_recovery), 1, "R7 precharge at k=twr");
        pulse_clear();
        chk(int'(err_wr_recovery), 0, "R9 recovery flag cleared");
        run_write(6'h0C, 3, 0, 1'b0, 1'b1, 1'b1, 3, 4, 8'hE0);
        @(negedge clk);
        chk(int'(err_wr_recovery), 0, "R7 precharge at k=twr+1");
        check_mem("R7 data kept");
    endtask

    initial begin
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) exp_mem[a] = '0;
        idle_bus();
        col_addr = '0; rd_addr = '0; err_clr = 1'b0;
        cfg_cas_lat = 3'd3; cfg_add_lat = 3'd0; cfg_bl8 = 1'b0; cfg_twr = 3'd2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bl4_wrap();
        t_bl8_al();
        t_wl_one();
        t_not_write();
        t_bad_pre();
        t_twr();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule